// File: doc/BRIEF.md
# TDM Frame Sync Generator

This block sets the bit-level timing of a time-division-multiplexed audio port. As the timing master it divides the system clock into a serial bit clock and counts bit periods. Each frame lasts the programmed divisor plus one bit periods. The block drives a frame sync whose shape can be chosen: a pulse one bit long placed in the first bit of slot 0 or in the last bit of the previous frame, or a pulse that covers all of slot 0. As a timing slave it takes an external bit clock and frame sync, brings both into the system clock domain and aligns its own bit counter to the sync.

In both roles the block produces one-cycle strobes that mark the first bit of each frame and of each active slot. A datapath that shifts samples can use these strobes. A configuration checker compares the divisor with the slot length and slot count. If the frame is too short, it raises an error flag and keeps the port silent.

Top module: `tdm_sync_gen`

## Requirements
- R1: In master mode a frame lasts `frame_div`+1 bit periods, so consecutive `frame_start_o` pulses are (`frame_div`+1)·2·`HALF_DIV` system clocks apart.
- R2: When `frame_div`+1 is smaller than slot length × `slot_cnt`, `cfg_err_o` is 1, and from the next cycle on `fsync_o`, `frame_start_o` and `slot_start_o` stay 0. Equality is legal.
- R3: With `sync_long`=1 and `slot_cnt` ≤ 1 the configuration is also an error unless `frame_div`+1 is strictly greater than the slot length. The same values with `sync_long`=0 are legal.
- R4: `slot_len_sel` 0, 1 and 2 select slots of 8, 16 and 32 bits, and 3 is an error. `slot_start_o` pulses at bit positions 0, L, 2L … up to (`slot_cnt`−1)·L of each frame (L = slot length), and never in the padding bits after the last slot. Slot counts 1, 2, 4, 6 and 8 are supported.
- R5: With `sync_long`=0 and `sync_early`=0 (late), `fsync_o` is high only during bit 0 of each frame.
- R6: With `sync_long`=0 and `sync_early`=1 (early), `fsync_o` is high only during the last bit (position `frame_div`) of each frame.
- R7: With `sync_long`=1, `fsync_o` is high for bit positions 0 to L−1, whatever the value of `sync_early`.
- R8: While `en` is low no strobe and no sync is produced, and `bclk_o` rests at its idle level (`clk_inv` in master mode).
- R9: In master mode each bit period is 2·`HALF_DIV` system clocks. `bclk_o` XOR `clk_inv` is high for the first `HALF_DIV` clocks of the period, and its rising edge coincides with the bit's strobes and sync update.
- R10: With `slave_sel`=1, `bclk_o` and `fsync_o` are held at 0. A rising edge of the external sync, sampled at an external bit-clock edge (rising edge when `clk_inv`=0), restarts the frame. In late or long mode that bit becomes bit 0. In early mode it becomes the last bit, and the following bit is bit 0.
- R11: In slave mode, after a restart, the counter runs freely, and `frame_start_o` repeats every `frame_div`+1 external bits with no further sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Global enable |
| slave_sel | input | 1 | 0 = master (drives bit clock and sync), 1 = slave |
| sync_long | input | 1 | 0 = one-bit sync, 1 = sync lasts one slot |
| sync_early | input | 1 | One-bit sync placement: 0 = late, 1 = early |
| clk_inv | input | 1 | Bit clock polarity / slave sampling edge select |
| frame_div | input | DIV_W | Frame length in bits minus one |
| slot_len_sel | input | 2 | Slot length code (0 = 8, 1 = 16, 2 = 32 bits) |
| slot_cnt | input | CNT_W | Active slots per frame |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_sync | input | 1 | External frame sync (slave mode) |
| bclk_o | output | 1 | Generated bit clock |
| fsync_o | output | 1 | Generated frame sync |
| frame_start_o | output | 1 | One-cycle strobe at bit 0 of a frame |
| slot_start_o | output | 1 | One-cycle strobe at bit 0 of an active slot |
| cfg_err_o | output | 1 | Illegal configuration flag |

## Verification
The hardest case to reach from the ports is slave alignment. The restart depends on where the external sync edge falls relative to the external bit-clock edges, and it reaches the strobes only after the synchronizers. The bench therefore drives the external clock with a known number of system clocks per bit and keeps its own index of external bits. It raises the sync in one chosen bit, then records the index at which each frame and slot strobe appears, once in late mode and once in early mode. The limits of the legality rules are placed on either side of equality: a divisor exactly one bit too short, exactly long enough, and the long-sync single-slot limit.

// File: rtl/tdm_sync_pkg.sv
package tdm_sync_pkg;

    typedef enum logic [1:0] {
        SLOT_8   = 2'd0,
        SLOT_16  = 2'd1,
        SLOT_32  = 2'd2,
        SLOT_BAD = 2'd3
    } slot_code_e;

    typedef struct packed {
        logic       slave;
        logic       sync_long;
        logic       early;
        logic       inv;
        logic [1:0] slot_code;
    } mode_t;

    // slot length in bits for a slot code; 0 marks an unusable code
    function automatic logic [5:0] slot_bits(input logic [1:0] code);
        case (slot_code_e'(code))
            SLOT_8:  return 6'd8;
            SLOT_16: return 6'd16;
            SLOT_32: return 6'd32;
            default: return 6'd0;
        endcase
    endfunction

endpackage

// File: rtl/tdm_cfg_check.sv
module tdm_cfg_check
    import tdm_sync_pkg::*;
#(
    parameter int DIV_W = 10,
    parameter int CNT_W = 4
) (
    input  logic [DIV_W-1:0] div,
    input  logic [CNT_W-1:0] cnt,
    input  logic             sync_long,
    input  logic [1:0]       slot_code,
    output logic [5:0]       slot_len,
    output logic             err
);
    localparam int PW = DIV_W + CNT_W + 7;

    logic [PW-1:0] frame_bits;
    logic [PW-1:0] need_bits;
    logic [PW-1:0] len_w;

    always_comb begin
        slot_len   = slot_bits(slot_code);
        len_w      = PW'(slot_len);
        frame_bits = PW'(div) + PW'(1);
        need_bits  = len_w * PW'(cnt);
        err        = 1'b0;
        if (slot_code_e'(slot_code) == SLOT_BAD) begin
            err = 1'b1;
        end
        if (frame_bits < need_bits) begin
            err = 1'b1;
        end
        if (sync_long && (cnt <= CNT_W'(1)) && (frame_bits <= len_w)) begin
            err = 1'b1;
        end
    end

endmodule

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slave,
    input  logic inv,
    input  logic ext_bclk,
    input  logic ext_sync,
    output logic tick,
    output logic bclk_raw,
    output logic sync_lvl
);
    localparam int PER = 2 * HALF_DIV;
    localparam int CW  = (PER > 2) ? $clog2(PER) : 1;
    localparam logic [CW-1:0] LAST_C = CW'(PER - 1);
    localparam logic [CW-1:0] HALF_C = CW'(HALF_DIV);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
        logic          bclk;
        logic [2:0]    bsync;
        logic [1:0]    ssync;
    } timer_t;

    timer_t tm_q, tm_d;
    logic   tick_c;

    always_comb begin
        tm_d       = tm_q;
        tick_c     = 1'b0;
        tm_d.bsync = {tm_q.bsync[1:0], ext_bclk};
        tm_d.ssync = {tm_q.ssync[0], ext_sync};
        if (!run || slave) begin
            tm_d.cnt   = '0;
            tm_d.armed = 1'b0;
            tm_d.bclk  = 1'b0;
            if (run && slave) begin
                tick_c = inv ? (!tm_q.bsync[1] && tm_q.bsync[2])
                             : (tm_q.bsync[1] && !tm_q.bsync[2]);
            end
        end else if (!tm_q.armed) begin
            tm_d.armed = 1'b1;
            tm_d.cnt   = '0;
            tm_d.bclk  = 1'b1;
            tick_c     = 1'b1;
        end else begin
            tick_c    = (tm_q.cnt == LAST_C);
            tm_d.cnt  = tick_c ? '0 : tm_q.cnt + CW'(1);
            tm_d.bclk = (tm_d.cnt < HALF_C);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign tick     = tick_c;
    assign bclk_raw = tm_q.bclk;
    assign sync_lvl = tm_q.ssync[1];

    // R9
    bclk_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !slave && $rose(tm_q.bclk)) |-> (tm_q.cnt == '0));

endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
    parameter int DIV_W = 10,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             sync_lvl,
    input  logic             slave,
    input  logic             sync_long,
    input  logic             early,
    input  logic [DIV_W-1:0] div,
    input  logic [CNT_W-1:0] cnt,
    input  logic [5:0]       slot_len,
    output logic             fsync,
    output logic             frame_start,
    output logic             slot_start
);
    localparam int PW = DIV_W + CNT_W + 7;

    typedef struct packed {
        logic [DIV_W-1:0] pos;
        logic             started;
        logic             sync_prev;
        logic             fsync;
        logic             fs;
        logic             ss;
    } frame_t;

    frame_t           fr_q, fr_d;
    logic [DIV_W-1:0] pos_n;
    logic             adv;
    logic             rise;
    logic [PW-1:0]    pos_w;
    logic [PW-1:0]    len_w;
    logic [PW-1:0]    slots_end;

    always_comb begin
        fr_d      = fr_q;
        fr_d.fs   = 1'b0;
        fr_d.ss   = 1'b0;
        adv       = 1'b0;
        pos_n     = fr_q.pos;
        rise      = sync_lvl && !fr_q.sync_prev;
        len_w     = PW'(slot_len);
        slots_end = len_w * PW'(cnt);
        if (!run) begin
            fr_d = '0;
        end else if (tick) begin
            fr_d.sync_prev = sync_lvl;
            if (slave && rise) begin
                adv   = 1'b1;
                pos_n = (!sync_long && early) ? div : '0;
            end else if (!fr_q.started) begin
                if (!slave) begin
                    adv   = 1'b1;
                    pos_n = '0;
                end
            end else begin
                adv   = 1'b1;
                pos_n = (fr_q.pos == div) ? '0 : fr_q.pos + DIV_W'(1);
            end
        end
        pos_w = PW'(pos_n);
        if (run && tick && adv) begin
            fr_d.started = 1'b1;
            fr_d.pos     = pos_n;
            fr_d.fs      = (pos_n == '0);
            fr_d.ss      = (pos_w < slots_end) && ((pos_w & (len_w - PW'(1))) == '0);
            if (slave) begin
                fr_d.fsync = 1'b0;
            end else if (sync_long) begin
                fr_d.fsync = (pos_w < len_w);
            end else if (early) begin
                fr_d.fsync = (pos_n == div);
            end else begin
                fr_d.fsync = (pos_n == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign fsync       = fr_q.fsync;
    assign frame_start = fr_q.fs;
    assign slot_start  = fr_q.ss;

    // R5
    late_sync_chk: assert property (@(posedge clk) disable iff (!rst_n || !run)
        (!slave && !sync_long && !early && $rose(fr_q.fsync)) |-> fr_q.fs);

    // R6
    early_sync_chk: assert property (@(posedge clk) disable iff (!rst_n || !run)
        (!slave && !sync_long && early && $fell(fr_q.fsync)) |-> fr_q.fs);

    // R7
    long_sync_chk: assert property (@(posedge clk) disable iff (!rst_n || !run)
        (!slave && sync_long && fr_q.fs) |-> fr_q.fsync);

endmodule

// File: rtl/tdm_sync_gen.sv
module tdm_sync_gen
    import tdm_sync_pkg::*;
#(
    parameter int DIV_W    = 10,
    parameter int CNT_W    = 4,
    parameter int HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             slave_sel,
    input  logic             sync_long,
    input  logic             sync_early,
    input  logic             clk_inv,
    input  logic [DIV_W-1:0] frame_div,
    input  logic [1:0]       slot_len_sel,
    input  logic [CNT_W-1:0] slot_cnt,
    input  logic             ext_bclk,
    input  logic             ext_sync,
    output logic             bclk_o,
    output logic             fsync_o,
    output logic             frame_start_o,
    output logic             slot_start_o,
    output logic             cfg_err_o
);
    typedef struct packed {
        logic             en;
        mode_t            mode;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] cnt;
        logic             err;
    } top_t;

    top_t       top_q, top_d;
    logic       chk_err;
    logic [5:0] slot_len;
    logic       run;
    logic       tick;
    logic       bclk_raw;
    logic       sync_lvl;

    tdm_cfg_check #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_check (
        .div       (top_q.div),
        .cnt       (top_q.cnt),
        .sync_long (top_q.mode.sync_long),
        .slot_code (top_q.mode.slot_code),
        .slot_len  (slot_len),
        .err       (chk_err)
    );

    always_comb begin
        top_d                = top_q;
        top_d.en             = en;
        top_d.mode.slave     = slave_sel;
        top_d.mode.sync_long = sync_long;
        top_d.mode.early     = sync_early;
        top_d.mode.inv       = clk_inv;
        top_d.mode.slot_code = slot_len_sel;
        top_d.div            = frame_div;
        top_d.cnt            = slot_cnt;
        top_d.err            = chk_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign run = top_q.en && !top_q.err;

    tdm_bit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .slave    (top_q.mode.slave),
        .inv      (top_q.mode.inv),
        .ext_bclk (ext_bclk),
        .ext_sync (ext_sync),
        .tick     (tick),
        .bclk_raw (bclk_raw),
        .sync_lvl (sync_lvl)
    );

    tdm_frame_ctr #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .tick        (tick),
        .sync_lvl    (sync_lvl),
        .slave       (top_q.mode.slave),
        .sync_long   (top_q.mode.sync_long),
        .early       (top_q.mode.early),
        .div         (top_q.div),
        .cnt         (top_q.cnt),
        .slot_len    (slot_len),
        .fsync       (fsync_o),
        .frame_start (frame_start_o),
        .slot_start  (slot_start_o)
    );

    assign bclk_o    = top_q.mode.slave ? 1'b0 : (bclk_raw ^ top_q.mode.inv);
    assign cfg_err_o = top_q.err;

    // R2
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err_o && $past(cfg_err_o)) |-> (!fsync_o && !frame_start_o && !slot_start_o));

    // R8
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!top_q.en && !$past(top_q.en)) |-> (!fsync_o && !frame_start_o && !slot_start_o));

    // R4
    slot_with_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_o && (top_q.cnt != '0)) |-> slot_start_o);

endmodule

// File: tb/tb_tdm_sync_gen.sv
module tb_tdm_sync_gen;
    localparam int DIV_W = 10;
    localparam int CNT_W = 4;
    localparam int HALF  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             slave_sel = 1'b0;
    logic             sync_long = 1'b0;
    logic             sync_early = 1'b0;
    logic             clk_inv = 1'b0;
    logic [DIV_W-1:0] frame_div = 10'd15;
    logic [1:0]       slot_len_sel = 2'd0;
    logic [CNT_W-1:0] slot_cnt = 4'd2;
    logic             ext_bclk = 1'b0;
    logic             ext_sync = 1'b0;
    logic             bclk_o, fsync_o, frame_start_o, slot_start_o, cfg_err_o;

    tdm_sync_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W), .HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .slave_sel(slave_sel),
        .sync_long(sync_long), .sync_early(sync_early), .clk_inv(clk_inv),
        .frame_div(frame_div), .slot_len_sel(slot_len_sel), .slot_cnt(slot_cnt),
        .ext_bclk(ext_bclk), .ext_sync(ext_sync), .bclk_o(bclk_o), .fsync_o(fsync_o),
        .frame_start_o(frame_start_o), .slot_start_o(slot_start_o), .cfg_err_o(cfg_err_o)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // scoreboard: {fsync, frame_start, slot_start} expected at each bit clock rise
    logic [2:0] exp_q[$];
    string      cur_req = "R5";
    bit         mon_on = 1'b0;
    bit         prev_raw = 1'b0;
    int         last_rise = -1;
    int         last_fs = -1;
    int         period = 0;
    int         fs_gap = 0;
    int         hi_acc = 0;
    int         hi_last = 0;

    always @(negedge clk) begin
        bit raw;
        logic [2:0] e;
        if (mon_on) begin
            raw = bclk_o ^ clk_inv;
            if (raw && !prev_raw) begin
                if (last_rise >= 0) period = cyc - last_rise;
                last_rise = cyc;
                hi_last = hi_acc;
                hi_acc = 1;
                if (frame_start_o) begin
                    if (last_fs >= 0) fs_gap = cyc - last_fs;
                    last_fs = cyc;
                end
                if (exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    check({fsync_o, frame_start_o, slot_start_o} == e, cur_req,
                          "{fsync,frame,slot} at bit", int'({fsync_o, frame_start_o, slot_start_o}),
                          int'(e));
                end
            end else if (raw) begin
                hi_acc++;
            end
            prev_raw = raw;
        end else begin
            prev_raw = 1'b0;
            last_rise = -1;
            last_fs = -1;
            hi_acc = 0;
        end
    end

    function automatic logic [2:0] expect_bit(int pos, int div, int len, int cnt,
                                              bit lng, bit erl);
        logic fsy, fs, ss;
        fs = (pos == 0);
        ss = (pos < len * cnt) && (pos % len == 0);
        if (lng) fsy = (pos < len);
        else if (erl) fsy = (pos == div);
        else fsy = (pos == 0);
        return {fsy, fs, ss};
    endfunction

    task automatic configure(input bit slv, input bit lng, input bit erl, input bit inv,
                             input int div, input int code, input int cnt);
        en = 1'b0;
        repeat (4) @(negedge clk);
        slave_sel = slv;
        sync_long = lng;
        sync_early = erl;
        clk_inv = inv;
        frame_div = DIV_W'(div);
        slot_len_sel = 2'(code);
        slot_cnt = CNT_W'(cnt);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_master(input bit lng, input bit erl, input bit inv, input int div,
                              input int code, input int cnt, input int nbits, input string req);
        int len;
        int guard;
        len = 8 << code;
        configure(1'b0, lng, erl, inv, div, code, cnt);
        check(cfg_err_o == 1'b0, req, "cfg_err_o legal config", int'(cfg_err_o), 0);
        check(bclk_o == inv, "R8", "bclk_o idle level", int'(bclk_o), int'(inv));
        cur_req = req;
        for (int k = 0; k < nbits; k++) begin
            exp_q.push_back(expect_bit(k % (div + 1), div, len, cnt, lng, erl));
        end
        fs_gap = 0;
        mon_on = 1'b1;
        en = 1'b1;
        guard = 0;
        while (exp_q.size() > 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(exp_q.size() == 0, req, "scoreboard drained", exp_q.size(), 0);
        check(period == 2 * HALF, "R9", "bit period clocks", period, 2 * HALF);
        check(hi_last == HALF, "R9", "bit clock high clocks", hi_last, HALF);
        if (nbits > div + 1) begin
            check(fs_gap == (div + 1) * 2 * HALF, "R1", "frame spacing clocks",
                  fs_gap, (div + 1) * 2 * HALF);
        end
        en = 1'b0;
        repeat (3) @(negedge clk);
        mon_on = 1'b0;
        exp_q.delete();
    endtask

    task automatic quiet_window(input int ncyc, input string req);
        int act;
        act = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (fsync_o || frame_start_o || slot_start_o) act++;
        end
        check(act == 0, req, "cycles with sync or strobe", act, 0);
    endtask

    // slave stimulus and capture
    int ext_bit = -1;
    bit smon = 1'b0;
    int fs_bits[$];
    int ss_n = 0;
    int sbad = 0;

    always @(negedge clk) begin
        if (smon) begin
            if (frame_start_o) fs_bits.push_back(ext_bit);
            if (slot_start_o) ss_n++;
            if (fsync_o || bclk_o) sbad++;
        end
    end

    task automatic run_slave(input bit erl, input string req);
        int first;
        configure(1'b1, 1'b0, erl, 1'b0, 15, 0, 2);
        fs_bits.delete();
        ss_n = 0;
        sbad = 0;
        ext_bclk = 1'b0;
        ext_sync = 1'b0;
        en = 1'b1;
        repeat (4) @(negedge clk);
        smon = 1'b1;
        for (int b = 0; b < 40; b++) begin
            ext_bclk = 1'b1;
            ext_bit = b;
            repeat (4) @(negedge clk);
            ext_bclk = 1'b0;
            ext_sync = (b + 1 == 3);
            repeat (4) @(negedge clk);
        end
        smon = 1'b0;
        en = 1'b0;
        first = erl ? 4 : 3;
        check(fs_bits.size() == 3, req, "slave frame strobes", fs_bits.size(), 3);
        for (int i = 0; i < 3; i++) begin
            int got;
            got = (i < fs_bits.size()) ? fs_bits[i] : -1;
            check(got == first + 16 * i, (i == 0) ? req : "R11", "frame strobe at ext bit",
                  got, first + 16 * i);
        end
        check(ss_n == 5, "R11", "slave slot strobes", ss_n, 5);
        check(sbad == 0, "R10", "slave bclk_o/fsync_o driven", sbad, 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R8 reset / disabled state
        check(bclk_o == 1'b0, "R8", "reset bclk_o", int'(bclk_o), 0);
        check(fsync_o == 1'b0, "R8", "reset fsync_o", int'(fsync_o), 0);
        check(frame_start_o == 1'b0 && slot_start_o == 1'b0, "R8", "reset strobes",
              int'({frame_start_o, slot_start_o}), 0);
        check(cfg_err_o == 1'b0, "R2", "reset cfg_err_o", int'(cfg_err_o), 0);

        // R5 late short sync, 8-bit slots x2, 16-bit frame
        run_master(1'b0, 1'b0, 1'b0, 15, 0, 2, 34, "R5");
        // R6 early short sync
        run_master(1'b0, 1'b1, 1'b0, 15, 0, 2, 34, "R6");
        // R7 long sync with early set (ignored); 16-bit x4 fills 64 exactly (R2 boundary legal)
        run_master(1'b1, 1'b1, 1'b0, 63, 1, 4, 66, "R7");
        // R4 32-bit slots x8, plus padding frame of 8-bit x6 inside 64
        run_master(1'b0, 1'b0, 1'b0, 255, 2, 8, 258, "R4");
        run_master(1'b0, 1'b0, 1'b0, 63, 0, 6, 66, "R4");
        // R9 inverted polarity
        run_master(1'b0, 1'b0, 1'b1, 7, 0, 1, 10, "R9");

        // R8 enable low with inverted polarity: idle high, nothing produced
        configure(1'b0, 1'b0, 1'b0, 1'b1, 15, 0, 2);
        check(bclk_o == 1'b1, "R8", "bclk_o idle with clk_inv", int'(bclk_o), 1);
        quiet_window(60, "R8");
        check(bclk_o == 1'b1, "R8", "bclk_o still idle", int'(bclk_o), 1);

        // R2 frame one bit too short
        configure(1'b0, 1'b0, 1'b0, 1'b0, 62, 1, 4);
        check(cfg_err_o == 1'b1, "R2", "cfg_err_o short frame", int'(cfg_err_o), 1);
        en = 1'b1;
        quiet_window(200, "R2");
        en = 1'b0;

        // R3 long sync single slot boundary
        configure(1'b0, 1'b1, 1'b0, 1'b0, 15, 1, 1);
        check(cfg_err_o == 1'b1, "R3", "long, 1 slot, frame == slot", int'(cfg_err_o), 1);
        en = 1'b1;
        quiet_window(100, "R3");
        en = 1'b0;
        configure(1'b0, 1'b0, 1'b0, 1'b0, 15, 1, 1);
        check(cfg_err_o == 1'b0, "R3", "short, 1 slot, frame == slot", int'(cfg_err_o), 0);
        run_master(1'b1, 1'b0, 1'b0, 16, 1, 1, 19, "R3");

        // R4 reserved slot code
        configure(1'b0, 1'b0, 1'b0, 1'b0, 255, 3, 1);
        check(cfg_err_o == 1'b1, "R4", "slot code 3 flagged", int'(cfg_err_o), 1);

        // R10 slave alignment, late and early
        run_slave(1'b0, "R10");
        run_slave(1'b1, "R10");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule